// File: doc/BRIEF.md
# Per-Partition Cache Capacity Limit Bank

This block stores a cache capacity ceiling for every partition index, kept apart for each of four security spaces (secure, non-secure, root, realm). Each space owns a selector register that names one partition, and a 32-bit limit word at a fixed offset. A read or write of the limit word goes to the table entry that the selector of the same space currently names. The limit word carries an unsigned capacity fraction below one and a soft-limit flag.

Only the top `FRAC_W` bits of the 16-bit fraction are stored. The bits below them read as zero and ignore writes. The soft-limit flag exists only when `HAS_SOFT` is 1. A separate read-only lookup port gives the allocation logic the fraction and flag for any space and partition pair in the same cycle.

Top module: `caplim_bank`

## Requirements
- R1: The limit word sits at offset 0x108. Bit 31 is the soft-limit flag, bits 30:16 read as zero, and bits 15:0 hold the fraction.
- R2: The selector sits at offset 0x100. A write keeps the low `PIDX_W` bits of the write data, and a read returns that value zero-extended. It resets to 0.
- R3: A limit word access reaches the table entry named by the selector of the space given on `reg_space`.
- R4: The space codes are 0 secure, 1 non-secure, 2 root and 3 realm. Each space has its own selector and its own table, and an access in one space never changes another space.
- R5: Only fraction bits 15 down to 16-`FRAC_W` are stored. The bits below them always read as zero and drop written ones.
- R6: When `HAS_SOFT`=1 bit 31 is stored per entry. When `HAS_SOFT`=0 it reads as zero on both the register port and the lookup port.
- R7: While a selector holds a value at or above `NUM_PART`, limit word writes in that space change no entry and limit word reads return zero.
- R8: Reset (synchronous, active low) sets every implemented fraction bit to one and every soft flag to zero.
- R9: The lookup port returns the stored fraction and flag of (`lk_space`, `lk_pid`) combinationally. It returns zero for a partition at or above `NUM_PART`.
- R10: A read at any offset other than 0x100 and 0x108 returns zero.
- R11: Writes take effect at the rising clock edge. Reads are combinational and show the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_space | input | 2 | Security space of the register access |
| reg_addr | input | 12 | Byte offset within the space's frame |
| reg_wen | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_space/reg_addr |
| lk_space | input | 2 | Lookup space |
| lk_pid | input | PIDX_W | Lookup partition index |
| lk_frac | output | 16 | Stored fraction for the lookup pair |
| lk_soft | output | 1 | Stored soft-limit flag for the lookup pair |

## Verification
The bound checker watches several properties on every cycle. It checks that the reserved and unimplemented bits read as zero and that a missing soft-limit feature never shows a flag. It checks that out-of-range lookups and unmapped offsets return zero, and that the state right after reset holds the reset values. Using a shadow copy of each space's selector, it also checks that a limit write is read back correctly in the next cycle. Only the bench's scenarios can show the following: space isolation across a long sequence of writes, the absence of aliasing after an out-of-range write, the read-before-edge timing, and the behaviour of a second instance built without the soft flag.

// File: rtl/caplim_pkg.sv
// Shared constants and types for the capacity limit bank.
// Assumes a 12-bit byte offset per configuration frame.
package caplim_pkg;
    typedef enum logic [1:0] {
        SPC_SECURE = 2'd0,
        SPC_NONSEC = 2'd1,
        SPC_ROOT   = 2'd2,
        SPC_REALM  = 2'd3
    } space_e;

    localparam int          NUM_SPACES = 4;
    localparam int          OFS_W      = 12;
    localparam logic [11:0] OFS_SEL    = 12'h100;
    localparam logic [11:0] OFS_LIMIT  = 12'h108;
endpackage

// File: rtl/caplim_space.sv
// One security space: a partition selector plus a table of limit entries.
// Assumes NUM_PART <= 2**PIDX_W and 1 <= FRAC_W <= 16. Writes arrive
// already decoded (sel_we / lim_we). Reads and lookups are combinational.
module caplim_space #(
    parameter int NUM_PART = 16,
    parameter int PIDX_W   = 5,
    parameter int FRAC_W   = 8,
    parameter bit HAS_SOFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic              lim_we,
    input  logic [31:0]       wdata,
    output logic [PIDX_W-1:0] sel_q,
    output logic [31:0]       lim_word,
    input  logic [PIDX_W-1:0] lk_pid,
    output logic [15:0]       lk_frac,
    output logic              lk_soft
);
    localparam int                LOW_W    = 16 - FRAC_W;
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [PIDX_W:0]   NP_V     = NUM_PART[PIDX_W:0];

    logic [FRAC_W-1:0] frac_q [NUM_PART];
    logic              soft_q [NUM_PART];
    logic              sel_ok;
    logic              lk_ok;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    // Place the stored fraction bits at the top of the 16-bit field.
    function automatic logic [15:0] widen(input logic [FRAC_W-1:0] f);
        return 16'(f) << LOW_W;
    endfunction

    // Selector register: holds the partition index for limit accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= wdata[PIDX_W-1:0];
    end

    assign sel_ok = {1'b0, sel_q} < NP_V;
    assign lk_ok  = {1'b0, lk_pid} < NP_V;

    // One storage entry per partition; written only when selected and in range.
    for (genvar e = 0; e < NUM_PART; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frac_q[e] <= FRAC_MAX;
                soft_q[e] <= 1'b0;
            end else if (lim_we && sel_ok && sel_q == PIDX_W'(e)) begin
                frac_q[e] <= wdata[15 -: FRAC_W];
                soft_q[e] <= HAS_SOFT ? wdata[31] : 1'b0;
            end
        end
    end

    // Register-side read of the selected entry, zero when out of range.
    always_comb begin
        lim_word = '0;
        if (sel_ok)
            lim_word = {soft_q[sel_q], 15'b0, widen(frac_q[sel_q])};
    end

    // Lookup-side read for the allocation logic.
    always_comb begin
        lk_frac = '0;
        lk_soft = 1'b0;
        if (lk_ok) begin
            lk_frac = widen(frac_q[lk_pid]);
            lk_soft = soft_q[lk_pid];
        end
    end
endmodule

// File: rtl/caplim_bank.sv
// Top of the per-partition capacity limit bank: four independent space
// banks, address decode, register read mux and lookup mux.
// Assumes single-cycle register accesses with combinational read data.
module caplim_bank
    import caplim_pkg::*;
#(
    parameter int NUM_PART = 16,
    parameter int PIDX_W   = 5,
    parameter int FRAC_W   = 8,
    parameter bit HAS_SOFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_space,
    input  logic [11:0]       reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        lk_space,
    input  logic [PIDX_W-1:0] lk_pid,
    output logic [15:0]       lk_frac,
    output logic              lk_soft
);
    logic              hit_sel;
    logic              hit_lim;
    logic [PIDX_W-1:0] sel_v  [NUM_SPACES];
    logic [31:0]       word_v [NUM_SPACES];
    logic [15:0]       frac_v [NUM_SPACES];
    logic              soft_v [NUM_SPACES];

    // Offset decode shared by all spaces.
    assign hit_sel = (reg_addr == OFS_SEL);
    assign hit_lim = (reg_addr == OFS_LIMIT);

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
        caplim_space #(
            .NUM_PART (NUM_PART),
            .PIDX_W   (PIDX_W),
            .FRAC_W   (FRAC_W),
            .HAS_SOFT (HAS_SOFT)
        ) u_space (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_we   (reg_wen && hit_sel && reg_space == 2'(s)),
            .lim_we   (reg_wen && hit_lim && reg_space == 2'(s)),
            .wdata    (reg_wdata),
            .sel_q    (sel_v[s]),
            .lim_word (word_v[s]),
            .lk_pid   (lk_pid),
            .lk_frac  (frac_v[s]),
            .lk_soft  (soft_v[s])
        );
    end

    // Register read mux: selector, limit word, or zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_sel)
            reg_rdata = 32'(sel_v[reg_space]);
        else if (hit_lim)
            reg_rdata = word_v[reg_space];
    end

    // Lookup mux by space.
    assign lk_frac = frac_v[lk_space];
    assign lk_soft = soft_v[lk_space];
endmodule

// File: rtl/caplim_bank_chk.sv
// Checker for caplim_bank, attached by bind. Keeps a shadow of each
// space's selector taken from the register port only.
module caplim_bank_chk #(
    parameter int NUM_PART = 16,
    parameter int PIDX_W   = 5,
    parameter int FRAC_W   = 8,
    parameter bit HAS_SOFT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_space,
    input logic [11:0]       reg_addr,
    input logic              reg_wen,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [1:0]        lk_space,
    input logic [PIDX_W-1:0] lk_pid,
    input logic [15:0]       lk_frac,
    input logic              lk_soft
);
    localparam logic [15:0]     KEEP = 16'hFFFF << (16 - FRAC_W);
    localparam logic [PIDX_W:0] NP_V = NUM_PART[PIDX_W:0];

    logic [PIDX_W-1:0] sh_sel [4];
    logic              exp_vld_q;
    logic [1:0]        exp_spc_q;
    logic [31:0]       exp_q;
    logic              unused_chk;

    assign unused_chk = ^lk_space;

    // Shadow selectors and the expected read-back of the last limit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) sh_sel[s] <= '0;
            exp_vld_q <= 1'b0;
            exp_spc_q <= '0;
            exp_q     <= '0;
        end else begin
            if (reg_wen && reg_addr == 12'h100)
                sh_sel[reg_space] <= reg_wdata[PIDX_W-1:0];
            exp_vld_q <= reg_wen && reg_addr == 12'h108;
            exp_spc_q <= reg_space;
            if ({1'b0, sh_sel[reg_space]} < NP_V)
                exp_q <= {reg_wdata[31] & HAS_SOFT, 15'b0, reg_wdata[15:0] & KEEP};
            else
                exp_q <= '0;
        end
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 12'h108 |-> reg_rdata[30:16] == 15'b0);

    assert_sel_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 12'h100 |-> reg_rdata == 32'(sh_sel[reg_space]));

    // R3 and R7: the next read of the same space's limit word shows the write
    assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_vld_q && reg_addr == 12'h108 && reg_space == exp_spc_q) |-> reg_rdata == exp_q);

    assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_frac & ~KEEP) == 16'h0) && (reg_addr != 12'h108 || (reg_rdata[15:0] & ~KEEP) == 16'h0));

    assert_no_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_SOFT |-> (!lk_soft && (reg_addr != 12'h108 || !reg_rdata[31])));

    assert_reset_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && {1'b0, lk_pid} < NP_V) |-> (lk_frac == KEEP && !lk_soft));

    assert_lookup_oor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, lk_pid} >= NP_V) |-> (lk_frac == 16'h0 && !lk_soft));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 12'h100 && reg_addr != 12'h108) |-> reg_rdata == 32'h0);
endmodule

bind caplim_bank caplim_bank_chk #(
    .NUM_PART (NUM_PART),
    .PIDX_W   (PIDX_W),
    .FRAC_W   (FRAC_W),
    .HAS_SOFT (HAS_SOFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_space (reg_space),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lk_space  (lk_space),
    .lk_pid    (lk_pid),
    .lk_frac   (lk_frac),
    .lk_soft   (lk_soft)
);

// File: tb/caplim_bank_bench.sv
// Bench: a vector table walked by one loop, then directed tests.
module caplim_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_space = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, nr_rdata;
    logic [1:0]  lk_space = '0;
    logic [4:0]  lk_pid = '0;
    logic [15:0] lk_frac, nr_frac;
    logic        lk_soft, nr_soft;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    caplim_bank u_caplim_bank (
        .clk(clk), .rst_n(rst_n), .reg_space(reg_space), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_space(lk_space), .lk_pid(lk_pid), .lk_frac(lk_frac), .lk_soft(lk_soft));

    // Second instance: 4 fraction bits, no soft flag (same stimulus).
    caplim_bank #(.FRAC_W(4), .HAS_SOFT(1'b0)) u_nosoft (
        .clk(clk), .rst_n(rst_n), .reg_space(reg_space), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(nr_rdata),
        .lk_space(lk_space), .lk_pid(lk_pid), .lk_frac(nr_frac), .lk_soft(nr_soft));

    // Fields: [82:79] req, [78:77] space, [76:65] addr, [64] wen, [63:32] wdata, [31:0] expected read
    localparam int NV = 21;
    localparam logic [82:0] VECS [NV] = '{
        {4'd8,  2'd1, 12'h108, 1'b0, 32'h0,        32'h0000FF00}, // R8 reset value
        {4'd2,  2'd1, 12'h100, 1'b1, 32'h3,        32'h0},
        {4'd3,  2'd1, 12'h108, 1'b1, 32'hFFFFABCD, 32'h0},
        {4'd3,  2'd1, 12'h108, 1'b0, 32'h0,        32'h8000AB00}, // R1 R3 R5 R6
        {4'd4,  2'd0, 12'h108, 1'b0, 32'h0,        32'h0000FF00}, // R4
        {4'd2,  2'd0, 12'h100, 1'b1, 32'h3,        32'h0},
        {4'd4,  2'd0, 12'h108, 1'b0, 32'h0,        32'h0000FF00}, // R4 separate table
        {4'd2,  2'd1, 12'h100, 1'b0, 32'h0,        32'h00000003}, // R2
        {4'd2,  2'd2, 12'h100, 1'b1, 32'h0000000F, 32'h0},
        {4'd5,  2'd2, 12'h108, 1'b1, 32'h00001234, 32'h0},
        {4'd5,  2'd2, 12'h108, 1'b0, 32'h0,        32'h00001200}, // R5
        {4'd7,  2'd3, 12'h100, 1'b1, 32'h00000014, 32'h0},
        {4'd7,  2'd3, 12'h108, 1'b1, 32'h8000FFFF, 32'h0},
        {4'd7,  2'd3, 12'h108, 1'b0, 32'h0,        32'h0},        // R7 read zero
        {4'd7,  2'd3, 12'h100, 1'b1, 32'h4,        32'h0},
        {4'd7,  2'd3, 12'h108, 1'b0, 32'h0,        32'h0000FF00}, // R7 no aliasing
        {4'd2,  2'd1, 12'h100, 1'b1, 32'hFFFFFFE5, 32'h0},
        {4'd2,  2'd1, 12'h100, 1'b0, 32'h0,        32'h00000005}, // R2 truncation
        {4'd3,  2'd1, 12'h108, 1'b1, 32'h0,        32'h0},
        {4'd3,  2'd1, 12'h108, 1'b0, 32'h0,        32'h0},        // R3
        {4'd10, 2'd0, 12'h200, 1'b0, 32'h0,        32'h0}         // R10
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sp, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_space = sp; reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [1:0] sp, input logic [11:0] a,
                            input logic [31:0] exp);
        @(negedge clk);
        reg_space = sp; reg_addr = a; reg_wen = 1'b0;
        #1 check32(req, reg_rdata, exp);
    endtask

    task automatic lookup(input string req, input logic [1:0] sp, input logic [4:0] p,
                          input logic [15:0] ef, input logic es);
        @(negedge clk);
        lk_space = sp; lk_pid = p;
        #1 check32(req, {15'b0, lk_soft, lk_frac}, {15'b0, es, ef});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_space = VECS[i][78:77];
            reg_addr  = VECS[i][76:65];
            reg_wen   = VECS[i][64];
            reg_wdata = VECS[i][63:32];
            if (!VECS[i][64]) begin
                #1 check32($sformatf("R%0d vec %0d", VECS[i][82:79], i), reg_rdata, VECS[i][31:0]);
            end
        end
        @(negedge clk);
        reg_wen = 1'b0;

        // R9: lookup port for several pairs
        lookup("R9 sp1 pid3", 2'd1, 5'd3, 16'hAB00, 1'b1);
        lookup("R9 sp1 pid5", 2'd1, 5'd5, 16'h0000, 1'b0);
        lookup("R9 sp2 pid15", 2'd2, 5'd15, 16'h1200, 1'b0);
        lookup("R4 sp0 pid3", 2'd0, 5'd3, 16'hFF00, 1'b0);
        lookup("R9 out of range", 2'd1, 5'd20, 16'h0000, 1'b0);
        lookup("R7 sp3 pid4 untouched", 2'd3, 5'd4, 16'hFF00, 1'b0);

        // R6 / R5: instance without soft flag and with 4 fraction bits
        reg_write(2'd0, 12'h108, 32'hFFFFFFFF);
        reg_read("R6 soft stored", 2'd0, 12'h108, 32'h8000FF00);
        check32("R6 R5 no-soft instance read", nr_rdata, 32'h0000F000);
        lookup("R6 main lookup", 2'd0, 5'd3, 16'hFF00, 1'b1);
        check32("R6 no-soft lookup", {15'b0, nr_soft, nr_frac}, 32'h0000F000);

        // R11: read before the write edge shows the old value, after shows the new
        @(negedge clk);
        reg_space = 2'd2; reg_addr = 12'h108; reg_wdata = 32'h00005600; reg_wen = 1'b1;
        #1 check32("R11 before edge", reg_rdata, 32'h00001200);
        @(negedge clk);
        reg_wen = 1'b0;
        #1 check32("R11 after edge", reg_rdata, 32'h00005600);

        // R8: reset mid-run restores entries and selectors
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reg_read("R2 selector after reset", 2'd1, 12'h100, 32'h0);
        lookup("R8 sp1 pid3 after reset", 2'd1, 5'd3, 16'hFF00, 1'b0);
        check32("R8 no-soft after reset", {15'b0, nr_soft, nr_frac}, 32'h0000F000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule